// File: doc/BRIEF.md
# Two-Output PWM Action Qualifier with Continuous Force

This block turns the events of an external time-base counter into two PWM levels, A and B. Each clock cycle in which `tick` is high is one counter step. The block takes the zero-match and period-match strobes and the current count with its direction. It compares the count against two compare registers of its own to form the compare-A and compare-B up-count events. For each output, a 16-bit action register tells the block what to do when each event occurs: nothing, drive low, drive high, or toggle.

A continuous force can hold either output low or high, whatever the events would do. Software writes the force value into a shadow register. The value becomes active at a reload point that software chooses: counter zero, counter period, either of these, or immediately.

All configuration goes through one plain write port. The event, count and tick inputs are sampled each cycle with no handshake. The block has no stream interface, so there is no back-pressure.

Top module: `pwm_action_qual`

## Requirements
- R1: Each output has its own action register. Its 2-bit fields are: counter zero at bits 1:0, counter period at bits 3:2, compare A while counting up at bits 5:4, and compare B while counting up at bits 9:8.
- R2: An action field value of 00 leaves the output unchanged. A value of 01 drives it low, 10 drives it high and 11 toggles it.
- R3: A compare event fires only on a tick when `count` equals that compare register and `count_up` is 1. The same count while counting down has no effect.
- R4: When several events with non-zero actions fire on one tick, one action applies, in this priority order: compare A, compare B, period, zero. An event whose field is 00 does not hide a lower-priority event.
- R5: The force shadow holds output A's field at bits 1:0 and output B's field at bits 3:2. A field of 01 forces the output low and 10 forces it high; 00 and 11 apply no force. An active force overrides every event action.
- R6: The reload field at bits 7:6 of the force-control register chooses when the shadow becomes active. The codes are 00 at a zero tick, 01 at a period tick, 10 at either, and 11 immediately. The new force level shows on the output after the reload tick; in immediate mode it shows after the first tick following the write.
- R7: When a force is released, the output keeps its level until the next event action.
- R8: The outputs change only on the clock edge that ends a cycle in which `tick` is high.
- R9: While `rst_n` is low, both outputs go low and all action, compare, force-shadow, active-force and reload fields clear.
- R10: A write with `cfg_we` high stores `cfg_wdata` into the register selected by `cfg_addr`. The addresses are 0 for action A, 1 for action B, 2 for compare A, 3 for compare B, 4 for force shadow and 5 for force control.
- R11: Output A goes high at zero and at period, and low at the compare-A up match; this gives a normal-polarity wave. Swapping the three actions gives the inverted wave.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 3 | Configuration register select |
| cfg_wdata | input | 16 | Configuration write data |
| tick | input | 1 | Counter step qualifier |
| count | input | 16 | Current counter value |
| count_up | input | 1 | 1 when the counter is counting up |
| evt_zero | input | 1 | Counter is at zero |
| evt_period | input | 1 | Counter is at period |
| pwm_a | output | 1 | PWM output A |
| pwm_b | output | 1 | PWM output B |

## Verification
The bench fires several events on the same tick to confirm the priority order. It also checks that an event whose action field is 00 lets a lower-priority action through; a design that resolved priority on events alone would leave the output stuck. It repeats a compare value while counting down, where a comparator that ignores direction would switch the output. For each reload mode it checks that the force takes effect only at the chosen point. It then releases the force and confirms the output keeps its level, where a design that dropped back to low or to an old level would show a glitch.

// File: rtl/pwm_aq_pkg.sv
package pwm_aq_pkg;
  localparam int NUM_OUT = 2;

  typedef enum logic [1:0] {
    ACT_NONE   = 2'b00,
    ACT_LOW    = 2'b01,
    ACT_HIGH   = 2'b10,
    ACT_TOGGLE = 2'b11
  } aq_act_e;

  typedef enum logic [1:0] {
    RLD_ZERO   = 2'b00,
    RLD_PERIOD = 2'b01,
    RLD_EITHER = 2'b10,
    RLD_NOW    = 2'b11
  } aq_reload_e;

  // action field positions inside an action register
  localparam int FLD_ZERO = 0;
  localparam int FLD_PRD  = 2;
  localparam int FLD_CMPA = 4;
  localparam int FLD_CMPB = 8;
  // reload field position inside the force-control register
  localparam int FLD_RELOAD = 6;

  localparam logic [2:0] ADDR_ACT_A  = 3'd0;
  localparam logic [2:0] ADDR_ACT_B  = 3'd1;
  localparam logic [2:0] ADDR_CMP_A  = 3'd2;
  localparam logic [2:0] ADDR_CMP_B  = 3'd3;
  localparam logic [2:0] ADDR_FRC_SH = 3'd4;
  localparam logic [2:0] ADDR_FRC_CT = 3'd5;

  typedef struct packed {
    logic zero;
    logic period;
    logic cmp_a;
    logic cmp_b;
  } aq_events_t;

  function automatic logic apply_act(aq_act_e act, logic cur);
    case (act)
      ACT_LOW:    return 1'b0;
      ACT_HIGH:   return 1'b1;
      ACT_TOGGLE: return ~cur;
      default:    return cur;
    endcase
  endfunction
endpackage

// File: rtl/pwm_aq_regs.sv
module pwm_aq_regs
  import pwm_aq_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       we,
  input  logic [2:0]                 addr,
  input  logic [DW-1:0]              wdata,
  output logic [NUM_OUT-1:0][DW-1:0] act,
  output logic [NUM_OUT-1:0][DW-1:0] cmp,
  output logic [2*NUM_OUT-1:0]       frc_shadow,
  output aq_reload_e                 reload_sel
);
  localparam int FW = 2 * NUM_OUT;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act        <= '0;
      cmp        <= '0;
      frc_shadow <= '0;
      reload_sel <= RLD_ZERO;
    end else if (we) begin
      case (addr)
        ADDR_ACT_A:  act[0]     <= wdata;
        ADDR_ACT_B:  act[1]     <= wdata;
        ADDR_CMP_A:  cmp[0]     <= wdata;
        ADDR_CMP_B:  cmp[1]     <= wdata;
        ADDR_FRC_SH: frc_shadow <= wdata[FW-1:0];
        ADDR_FRC_CT: reload_sel <= aq_reload_e'(wdata[FLD_RELOAD +: 2]);
        default: ;
      endcase
    end
  end

  // R10: a write to a compare register lands the next cycle
  a_r10_cmp_a_write: assert property (@(posedge clk) disable iff (!rst_n)
    (we && addr == ADDR_CMP_A) |=> (cmp[0] == $past(wdata)));
endmodule

// File: rtl/pwm_aq_events.sv
module pwm_aq_events
  import pwm_aq_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic                       tick,
  input  logic                       evt_zero,
  input  logic                       evt_period,
  input  logic [DW-1:0]              count,
  input  logic                       count_up,
  input  logic [NUM_OUT-1:0][DW-1:0] cmp,
  output aq_events_t                 ev
);
  logic [NUM_OUT-1:0] hit;

  for (genvar i = 0; i < NUM_OUT; i++) begin : g_cmp
    assign hit[i] = tick && count_up && (count == cmp[i]);
  end

  assign ev.zero   = tick && evt_zero;
  assign ev.period = tick && evt_period;
  assign ev.cmp_a  = hit[0];
  assign ev.cmp_b  = hit[1];
endmodule

// File: rtl/pwm_aq_force.sv
module pwm_aq_force
  import pwm_aq_pkg::*;
#(
  parameter int FW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          evt_zero,
  input  logic          evt_period,
  input  aq_reload_e    reload_sel,
  input  logic [FW-1:0] shadow,
  output logic [FW-1:0] eff
);
  logic [FW-1:0] active_q;
  logic          load;

  always_comb begin
    case (reload_sel)
      RLD_ZERO:   load = tick && evt_zero;
      RLD_PERIOD: load = tick && evt_period;
      RLD_EITHER: load = tick && (evt_zero || evt_period);
      default:    load = 1'b1;
    endcase
  end

  assign eff = load ? shadow : active_q;

  always_ff @(posedge clk) begin
    if (!rst_n) active_q <= '0;
    else        active_q <= eff;
  end

  // R6: outside immediate mode the active force only moves on a tick
  a_r6_active_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && reload_sel != RLD_NOW) |=> $stable(active_q));
endmodule

// File: rtl/pwm_aq_channel.sv
module pwm_aq_channel
  import pwm_aq_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  aq_events_t    ev,
  input  logic [DW-1:0] act,
  input  logic [1:0]    frc,
  output logic          out
);
  aq_act_e a_zero, a_prd, a_ca, a_cb, sel;
  logic    out_q, nxt;

  assign a_zero = aq_act_e'(act[FLD_ZERO +: 2]);
  assign a_prd  = aq_act_e'(act[FLD_PRD  +: 2]);
  assign a_ca   = aq_act_e'(act[FLD_CMPA +: 2]);
  assign a_cb   = aq_act_e'(act[FLD_CMPB +: 2]);

  // later assignments win: compare A > compare B > period > zero
  always_comb begin
    sel = ACT_NONE;
    if (ev.zero   && a_zero != ACT_NONE) sel = a_zero;
    if (ev.period && a_prd  != ACT_NONE) sel = a_prd;
    if (ev.cmp_b  && a_cb   != ACT_NONE) sel = a_cb;
    if (ev.cmp_a  && a_ca   != ACT_NONE) sel = a_ca;
    nxt = apply_act(sel, out_q);
    if (frc == 2'b01)      nxt = 1'b0;
    else if (frc == 2'b10) nxt = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)    out_q <= 1'b0;
    else if (tick) out_q <= nxt;
  end

  assign out = out_q;

  // R8: no tick, no change
  a_r8_hold_without_tick: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(out));
  // R5: an active force wins over any event
  a_r5_force_low: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && frc == 2'b01) |=> !out);
  a_r5_force_high: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && frc == 2'b10) |=> out);
endmodule

// File: rtl/pwm_action_qual.sv
module pwm_action_qual
  import pwm_aq_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [2:0]    cfg_addr,
  input  logic [DW-1:0] cfg_wdata,
  input  logic          tick,
  input  logic [DW-1:0] count,
  input  logic          count_up,
  input  logic          evt_zero,
  input  logic          evt_period,
  output logic          pwm_a,
  output logic          pwm_b
);
  localparam int FW = 2 * NUM_OUT;

  logic [NUM_OUT-1:0][DW-1:0] act, cmp;
  logic [FW-1:0]              frc_shadow, frc_eff;
  aq_reload_e                 reload_sel;
  aq_events_t                 ev;
  logic [NUM_OUT-1:0]         outs;

  pwm_aq_regs #(.DW(DW)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
    .act(act), .cmp(cmp), .frc_shadow(frc_shadow), .reload_sel(reload_sel)
  );

  pwm_aq_events #(.DW(DW)) u_events (
    .tick(tick), .evt_zero(evt_zero), .evt_period(evt_period),
    .count(count), .count_up(count_up), .cmp(cmp), .ev(ev)
  );

  pwm_aq_force #(.FW(FW)) u_force (
    .clk(clk), .rst_n(rst_n), .tick(tick), .evt_zero(evt_zero),
    .evt_period(evt_period), .reload_sel(reload_sel),
    .shadow(frc_shadow), .eff(frc_eff)
  );

  for (genvar i = 0; i < NUM_OUT; i++) begin : g_out
    pwm_aq_channel #(.DW(DW)) u_chan (
      .clk(clk), .rst_n(rst_n), .tick(tick), .ev(ev), .act(act[i]),
      .frc(frc_eff[2*i +: 2]), .out(outs[i])
    );
  end

  assign pwm_a = outs[0];
  assign pwm_b = outs[1];

  // R9: reset drives both outputs low
  a_r9_reset_low: assert property (@(posedge clk)
    !rst_n |=> (!pwm_a && !pwm_b));
  // R3: a down-count tick with no zero/period event and no force changes nothing
  a_r3_no_down_compare: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !count_up && !evt_zero && !evt_period &&
     (frc_eff[1:0] == 2'b00 || frc_eff[1:0] == 2'b11) &&
     (frc_eff[3:2] == 2'b00 || frc_eff[3:2] == 2'b11))
    |=> $stable({pwm_a, pwm_b}));
endmodule

// File: tb/pwm_action_qual_test.sv
module pwm_action_qual_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_addr = '0;
  logic [15:0] cfg_wdata = '0;
  logic        tick = 1'b0;
  logic [15:0] count = '0;
  logic        count_up = 1'b1;
  logic        evt_zero = 1'b0;
  logic        evt_period = 1'b0;
  logic        pwm_a, pwm_b;
  int          checks = 0;
  int          errors = 0;

  always #5 clk = ~clk;

  pwm_action_qual uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .tick(tick), .count(count), .count_up(count_up),
    .evt_zero(evt_zero), .evt_period(evt_period), .pwm_a(pwm_a), .pwm_b(pwm_b)
  );

  task automatic check(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %0b expected %0b", req, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [15:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic step(logic z, logic p, logic [15:0] c, logic up, logic tk = 1'b1);
    @(negedge clk);
    tick = tk; evt_zero = z; evt_period = p; count = c; count_up = up;
    @(negedge clk);
    tick = 1'b0; evt_zero = 1'b0; evt_period = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); @(negedge clk); rst_n = 1'b1;
  endtask

  task automatic t_reset();
    do_reset();
    check("R9 reset pwm_a", pwm_a, 1'b0);
    check("R9 reset pwm_b", pwm_b, 1'b0);
  endtask

  task automatic t_polarity();
    wr(3'd0, 16'h001A); wr(3'd2, 16'd5);
    wr(3'd1, 16'h0205); wr(3'd3, 16'd3);
    step(1, 0, 0, 1);
    check("R11 A high at zero", pwm_a, 1'b1);
    check("R11 B low at zero", pwm_b, 1'b0);
    step(0, 0, 3, 1);
    check("R1 B high at cmp B", pwm_b, 1'b1);
    check("R1 A unchanged at cmp B", pwm_a, 1'b1);
    step(0, 0, 5, 1);
    check("R11 A low at cmp A", pwm_a, 1'b0);
    step(0, 1, 9, 1);
    check("R11 A high at period", pwm_a, 1'b1);
    check("R11 B low at period", pwm_b, 1'b0);
  endtask

  task automatic t_toggle();
    wr(3'd0, 16'h0003);
    step(1, 0, 0, 1);
    check("R2 toggle once", pwm_a, 1'b0);
    step(1, 0, 0, 1);
    check("R2 toggle twice", pwm_a, 1'b1);
    step(1, 0, 0, 1, 1'b0);
    check("R8 no tick no toggle", pwm_a, 1'b1);
  endtask

  task automatic t_direction();
    wr(3'd0, 16'h0021); wr(3'd2, 16'd7);
    step(1, 0, 0, 1);
    check("R2 zero low", pwm_a, 1'b0);
    step(0, 0, 7, 0);
    check("R3 down-count match ignored", pwm_a, 1'b0);
    step(0, 0, 6, 1);
    check("R3 non-match ignored", pwm_a, 1'b0);
    step(0, 0, 7, 1);
    check("R3 up-count match", pwm_a, 1'b1);
  endtask

  task automatic t_priority();
    wr(3'd0, 16'h0026); wr(3'd2, 16'd9);
    step(1, 1, 4, 1);
    check("R4 period over zero", pwm_a, 1'b0);
    step(1, 1, 9, 1);
    check("R4 compare over period", pwm_a, 1'b1);
    wr(3'd0, 16'h0001);
    step(1, 0, 0, 1);
    wr(3'd0, 16'h0120); wr(3'd2, 16'd2); wr(3'd3, 16'd2);
    step(0, 0, 2, 1);
    check("R4 R10 cmp A over cmp B", pwm_a, 1'b1);
    wr(3'd0, 16'h0001);
    step(1, 0, 0, 1);
    wr(3'd0, 16'h0002); wr(3'd2, 16'd0);
    step(1, 0, 0, 1);
    check("R4 none field does not block zero", pwm_a, 1'b1);
  endtask

  task automatic t_force_now();
    wr(3'd5, 16'h00C0);
    wr(3'd0, 16'h0002);
    wr(3'd4, 16'h0001);
    step(1, 0, 0, 1);
    check("R5 force low beats zero-high", pwm_a, 1'b0);
    wr(3'd4, 16'h0002);
    step(0, 0, 1, 1);
    check("R6 immediate force high", pwm_a, 1'b1);
    wr(3'd4, 16'h0000);
    step(0, 0, 1, 1);
    check("R7 release keeps level", pwm_a, 1'b1);
    wr(3'd0, 16'h0001);
    wr(3'd4, 16'h0003);
    step(1, 0, 0, 1);
    check("R5 code 11 not a force", pwm_a, 1'b0);
  endtask

  task automatic t_force_points();
    wr(3'd0, 16'h0000);
    wr(3'd4, 16'h0000);
    wr(3'd5, 16'h0000);
    wr(3'd4, 16'h0002);
    step(0, 0, 1, 1);
    check("R6 zero mode waits", pwm_a, 1'b0);
    step(0, 1, 1, 1);
    check("R6 zero mode ignores period", pwm_a, 1'b0);
    step(1, 0, 0, 1);
    check("R6 zero mode loads at zero", pwm_a, 1'b1);
    wr(3'd5, 16'h0040);
    wr(3'd4, 16'h0001);
    step(1, 0, 0, 1);
    check("R6 period mode ignores zero", pwm_a, 1'b1);
    step(0, 1, 0, 1);
    check("R6 period mode loads at period", pwm_a, 1'b0);
    wr(3'd5, 16'h0080);
    wr(3'd4, 16'h000A);
    step(1, 0, 0, 1);
    check("R6 either mode zero A", pwm_a, 1'b1);
    check("R5 either mode zero B high", pwm_b, 1'b1);
    wr(3'd4, 16'h0001);
    step(0, 1, 0, 1);
    check("R6 either mode period", pwm_a, 1'b0);
  endtask

  task automatic t_reset_clears();
    wr(3'd5, 16'h00C0);
    wr(3'd4, 16'h000A);
    wr(3'd0, 16'h0003);
    step(1, 0, 0, 1);
    do_reset();
    check("R9 reset A low", pwm_a, 1'b0);
    check("R9 reset B low", pwm_b, 1'b0);
    step(1, 1, 0, 1);
    check("R9 cleared actions and force A", pwm_a, 1'b0);
    check("R9 cleared actions and force B", pwm_b, 1'b0);
  endtask

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_polarity();
    t_toggle();
    t_direction();
    t_priority();
    t_force_now();
    t_force_points();
    t_reset_clears();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule